// File: doc/BRIEF.md
# Indexed Block-Transfer Control Register Slave

This block is a two-wire serial bus slave. It watches an oversampled clock line and data line and pulls the data line low when it has to, as an open-drain device does. Behind it sits a small bank of 8-bit control bytes. The bank drives a clock-distribution stage: drive-mode bits for power-down and stop, three mode-select bits, a per-output enable vector and a per-output free-run vector. The bank also holds one read-only identification byte.

Every access carries an index. To write, the master sends the device address with the write bit, a start index and a byte count, then that many data bytes. The slave acknowledges each data byte, stores it at the current index and advances the index. To read, the master sets the index the same way, issues a repeated START and sends the address with the read bit. The slave then returns a count byte first, followed by data bytes from the indexed position onward. A single-byte write is a block write with a count of one.

The line inputs are resynchronised into the system clock domain. All decisions are made on the detected edges of the clock line, so the slave only moves the data line while the clock line is low.

Top module: `smb_ctl_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7..1 equal the parameter DEV_ADDR (default 69h). Bit 0 selects read (1) or write (0). For any other address the slave leaves the ACK slot and the rest of the transfer released (SDA high).
- R2: In a block write (address+W, index, count N, N data bytes), every data byte is acknowledged and stored at the current index, and the index then advances by one.
- R3: A count byte of 00h is not acknowledged. The transfer is abandoned and no register changes.
- R4: Once N data bytes have been received, any further data byte in the same transfer is not acknowledged and is discarded.
- R5: After a repeated START and the address with the read bit, the slave first sends the count byte READ_COUNT (default 08h). It then sends data from the current index, advancing by one per byte, MSB first.
- R6: A master NACK on a read byte makes the slave release SDA and stop transmitting. A STOP at any point releases SDA and returns the slave to idle, and the next transfer works normally.
- R7: After reset: byte 0 reads 07h (mode_sel_o = 111b, both drive-mode outputs 0), byte 1 reads FFh (all enables set) and byte 2 reads 00h.
- R8: Byte 0 layout: bit 7 is pd_drive_o and bit 6 is stop_drive_o. Bits 2..0 go to mode_sel_o[2:0], where [2] is high-bandwidth select, [1] is PLL-versus-bypass select and [0] is divide-by-two select. Bits 5..3 always read 0 and ignore writes.
- R9: Byte 1 drives out_en_o and byte 2 drives free_run_o, with bit n for output n. Byte 3 is reserved and reads 00h. Byte 4 is read-only and reads {REV_ID, VENDOR_ID} = 05h. Writes to bytes 3 and 4 are acknowledged and discarded. Indexes 5 and above read 00h.
- R10: sda_pull_o changes only while SCL is low, outside START and STOP events. It is asserted only in acknowledge slots and read data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release |
| pd_drive_o | output | 1 | Power-down drive mode, byte 0 bit 7 |
| stop_drive_o | output | 1 | Stop drive mode, byte 0 bit 6 |
| mode_sel_o | output | 3 | Mode selects, byte 0 bits 2..0 |
| out_en_o | output | NOUT | Per-output enables, byte 1 |
| free_run_o | output | NOUT | Per-output free-run flags, byte 2 |

## Verification
The bench targets the zero count and the extra byte past the count. A design that got these wrong would acknowledge a meaningless transfer, or would spill a byte into the next register. It reads the count byte ahead of the data and crosses the end of the implemented bank. A slave that skipped the count or advanced its index on it would return every byte shifted by one place. Reserved bits and read-only bytes are written with all ones and read back, which exposes a bank that stores them. The bench aborts transfers with STOP or NACK mid-way and then runs a normal transfer: a slave stuck holding SDA low or stuck in a stale state fails that follow-up. A monitor counts any SDA change while the clock line is high, which would be read as a false START or STOP.

// File: rtl/smb_ctl_pkg.sv
package smb_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_OFFS,
      ST_CNT,
      ST_WR,
      ST_RD,
      ST_WAIT
   } smb_st_e;

   localparam logic [7:0] IDX_MODE = 8'd0;
   localparam logic [7:0] IDX_OE   = 8'd1;
   localparam logic [7:0] IDX_FREE = 8'd2;
   localparam logic [7:0] IDX_ID   = 8'd4;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_p;
   logic              sda_p;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[0] <= 1'b1;
                  sda_sh[0] <= 1'b1;
               end else begin
                  scl_sh[0] <= scl_i;
                  sda_sh[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_sh[g] <= 1'b1;
                  sda_sh[g] <= 1'b1;
               end else begin
                  scl_sh[g] <= scl_sh[g-1];
                  sda_sh[g] <= sda_sh[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_ctl_pkg::*;
#(
   parameter int NOUT      = 8,
   parameter int REV_ID    = 0,
   parameter int VENDOR_ID = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [7:0]      widx,
   input  logic [7:0]      wdata,
   input  logic [7:0]      ridx,
   output logic [7:0]      rdata,
   output logic            pd_drive,
   output logic            stop_drive,
   output logic [2:0]      mode_sel,
   output logic [NOUT-1:0] out_en,
   output logic [NOUT-1:0] free_run
);

   localparam logic [7:0] ID_BYTE = {REV_ID[3:0], VENDOR_ID[3:0]};

   logic       pd_q;
   logic       stp_q;
   logic [2:0] mode_q;
   logic [7:0] oe_q;
   logic [7:0] fr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q   <= 1'b0;
         stp_q  <= 1'b0;
         mode_q <= 3'b111;
         oe_q   <= 8'hFF;
         fr_q   <= 8'h00;
      end else if (we) begin
         case (widx)
            IDX_MODE: begin
               pd_q   <= wdata[7];
               stp_q  <= wdata[6];
               mode_q <= wdata[2:0];
            end
            IDX_OE:   oe_q <= wdata;
            IDX_FREE: fr_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (ridx)
         IDX_MODE: rdata = {pd_q, stp_q, 3'b000, mode_q};
         IDX_OE:   rdata = oe_q;
         IDX_FREE: rdata = fr_q;
         IDX_ID:   rdata = ID_BYTE;
         default:  rdata = 8'h00;
      endcase
   end

   assign pd_drive   = pd_q;
   assign stop_drive = stp_q;
   assign mode_sel   = mode_q;
   assign out_en     = oe_q[NOUT-1:0];
   assign free_run   = fr_q[NOUT-1:0];

   // R2: register contents move only on a write strobe
   p_hold_without_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(oe_q) && $stable(fr_q) && $stable(mode_q) && $stable(pd_q)));

endmodule

// File: rtl/smb_proto.sv
module smb_proto
   import smb_ctl_pkg::*;
#(
   parameter int DEV_ADDR   = 'h69,
   parameter int READ_COUNT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_ev,
   input  logic       stop_ev,
   input  logic [7:0] rdata,
   output logic       drive_low,
   output logic       we,
   output logic [7:0] widx,
   output logic [7:0] wdata,
   output logic [7:0] ridx
);

   localparam logic [6:0] ADDR7 = DEV_ADDR[6:0];
   localparam logic [7:0] CNT8  = READ_COUNT[7:0];

   smb_st_e    st;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic [7:0] idx;
   logic [7:0] wr_left;
   logic       in_ack;
   logic       rd_mode;

   wire byte_done = scl_fall && (bitcnt == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bitcnt    <= 4'd0;
         shreg     <= 8'h00;
         idx       <= 8'h00;
         wr_left   <= 8'h00;
         in_ack    <= 1'b0;
         rd_mode   <= 1'b0;
         drive_low <= 1'b0;
         we        <= 1'b0;
         widx      <= 8'h00;
         wdata     <= 8'h00;
      end else begin
         we <= 1'b0;
         if (start_ev) begin
            st        <= ST_ADDR;
            bitcnt    <= 4'd0;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
         end else if (stop_ev) begin
            st        <= ST_IDLE;
            bitcnt    <= 4'd0;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_OFFS, ST_CNT, ST_WR: begin
                  if (!in_ack) begin
                     if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                     end else if (byte_done) begin
                        bitcnt <= 4'd0;
                        in_ack <= 1'b1;
                        case (st)
                           ST_ADDR: begin
                              if (shreg[7:1] == ADDR7) begin
                                 drive_low <= 1'b1;
                                 rd_mode   <= shreg[0];
                              end else begin
                                 st     <= ST_WAIT;
                                 in_ack <= 1'b0;
                              end
                           end
                           ST_OFFS: begin
                              drive_low <= 1'b1;
                              idx       <= shreg;
                           end
                           ST_CNT: begin
                              if (shreg != 8'h00) begin
                                 drive_low <= 1'b1;
                                 wr_left   <= shreg;
                              end else begin
                                 st     <= ST_WAIT;
                                 in_ack <= 1'b0;
                              end
                           end
                           default: begin
                              if (wr_left != 8'h00) begin
                                 drive_low <= 1'b1;
                                 we        <= 1'b1;
                                 widx      <= idx;
                                 wdata     <= shreg;
                                 idx       <= idx + 8'd1;
                                 wr_left   <= wr_left - 8'd1;
                              end else begin
                                 st     <= ST_WAIT;
                                 in_ack <= 1'b0;
                              end
                           end
                        endcase
                     end
                  end else if (scl_fall) begin
                     in_ack    <= 1'b0;
                     drive_low <= 1'b0;
                     case (st)
                        ST_ADDR: begin
                           if (rd_mode) begin
                              st        <= ST_RD;
                              shreg     <= CNT8;
                              drive_low <= ~CNT8[7];
                           end else begin
                              st <= ST_OFFS;
                           end
                        end
                        ST_OFFS: st <= ST_CNT;
                        ST_CNT:  st <= ST_WR;
                        default: ;
                     endcase
                  end
               end
               ST_RD: begin
                  if (!in_ack) begin
                     if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                     end else if (byte_done) begin
                        bitcnt    <= 4'd0;
                        in_ack    <= 1'b1;
                        drive_low <= 1'b0;
                     end else if (scl_fall) begin
                        shreg     <= {shreg[6:0], 1'b0};
                        drive_low <= ~shreg[6];
                     end
                  end else begin
                     if (scl_rise && sda_s) begin
                        st     <= ST_WAIT;
                        in_ack <= 1'b0;
                     end else if (scl_fall) begin
                        in_ack    <= 1'b0;
                        shreg     <= rdata;
                        drive_low <= ~rdata[7];
                        idx       <= idx + 8'd1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ridx = idx;

   // R10: the pull-down moves only in a cycle that followed a low clock line
   p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drive_low) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

   // R6: a STOP always leaves the line released
   p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !drive_low);

   // R1: a foreign address is never acknowledged
   p_addr_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && !in_ack && byte_done && !start_ev && !stop_ev &&
       shreg[7:1] != ADDR7) |=> (st == ST_WAIT && !drive_low));

   // R3: a zero count is refused
   p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CNT && !in_ack && byte_done && !start_ev && !stop_ev &&
       shreg == 8'h00) |=> (st == ST_WAIT && !drive_low));

endmodule

// File: rtl/smb_ctl_slave.sv
module smb_ctl_slave #(
   parameter int DEV_ADDR    = 'h69,
   parameter int READ_COUNT  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NOUT        = 8,
   parameter int REV_ID      = 0,
   parameter int VENDOR_ID   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_pull_o,
   output logic            pd_drive_o,
   output logic            stop_drive_o,
   output logic [2:0]      mode_sel_o,
   output logic [NOUT-1:0] out_en_o,
   output logic [NOUT-1:0] free_run_o
);

   generate
      if (DEV_ADDR < 0 || DEV_ADDR > 127) begin : g_bad_addr
         $error("DEV_ADDR must fit in 7 bits");
      end
      if (READ_COUNT < 1 || READ_COUNT > 255) begin : g_bad_cnt
         $error("READ_COUNT must be 1..255");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NOUT < 1 || NOUT > 8) begin : g_bad_nout
         $error("NOUT must be 1..8");
      end
      if (REV_ID < 0 || REV_ID > 15 || VENDOR_ID < 0 || VENDOR_ID > 15) begin : g_bad_id
         $error("identification fields must fit in 4 bits");
      end
   endgenerate

   logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic       we;
   logic [7:0] widx, wdata, ridx, rdata;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   smb_proto #(.DEV_ADDR(DEV_ADDR), .READ_COUNT(READ_COUNT)) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .rdata     (rdata),
      .drive_low (sda_pull_o),
      .we        (we),
      .widx      (widx),
      .wdata     (wdata),
      .ridx      (ridx)
   );

   smb_reg_bank #(.NOUT(NOUT), .REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (we),
      .widx       (widx),
      .wdata      (wdata),
      .ridx       (ridx),
      .rdata      (rdata),
      .pd_drive   (pd_drive_o),
      .stop_drive (stop_drive_o),
      .mode_sel   (mode_sel_o),
      .out_en     (out_en_o),
      .free_run   (free_run_o)
   );

endmodule

// File: tb/smb_ctl_slave_tb.sv
module smb_ctl_slave_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic       pd_drive, stop_drive;
   logic [2:0] mode_sel;
   logic [7:0] out_en, free_run;
   wire        sda_bus = sda_m & ~sda_pull;

   int checks = 0;
   int errors = 0;
   int r10_viol = 0;
   logic prev_pull = 1'b0;

   localparam logic [7:0] AW = 8'hD2;
   localparam logic [7:0] AR = 8'hD3;

   // {index, written byte, expected read-back}
   localparam logic [23:0] VEC [7] = '{
      24'h00FFC7, 24'h003800, 24'h01A5A5, 24'h023C3C,
      24'h03FF00, 24'h04FF05, 24'h071200 };

   smb_ctl_slave u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_bus),
      .sda_pull_o   (sda_pull),
      .pd_drive_o   (pd_drive),
      .stop_drive_o (stop_drive),
      .mode_sel_o   (mode_sel),
      .out_en_o     (out_en),
      .free_run_o   (free_run)
   );

   always #4 clk = ~clk;

   // R10 monitor: line must not move while the clock line is high
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_pull != prev_pull)) r10_viol++;
      prev_pull <= sda_pull;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic q();
      repeat (10) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; q();
      sda_m = 1'b0; q();
      scl_m = 1'b0; q();
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      sda_m = 1'b0; q();
      scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; q();
      scl_m = 1'b1; q();
      sda_m = 1'b1; q();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; q();
      scl_m = 1'b1; q(); q();
      scl_m = 1'b0; q();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; q();
      scl_m = 1'b1; q();
      b = sda_bus; q();
      scl_m = 1'b0; q();
   endtask

   task automatic wb(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic rb(output logic [7:0] v, input logic mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~mack);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] v;
      string      tag;
      logic [7:0] exp_rst [8];
      exp_rst = '{8'h07, 8'hFF, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R7 reset state at the ports
      chk("R7 mode_sel", mode_sel, 3'b111);
      chk("R7 pd/stop", {pd_drive, stop_drive}, 0);
      chk("R7 out_en", out_en, 8'hFF);
      chk("R7 free_run", free_run, 8'h00);
      chk("R10 idle release", sda_pull, 0);

      // R5 block read of the whole bank from reset, count byte first
      bus_start();
      wb(AW, ack); chk("R1 addr W ack", ack, 1);
      wb(8'h00, ack); chk("R5 index ack", ack, 1);
      bus_rstart();
      wb(AR, ack); chk("R1 addr R ack", ack, 1);
      rb(v, 1'b1); chk("R5 count byte", v, 8'h08);
      for (int i = 0; i < 8; i++) begin
         rb(v, i != 7);
         chk((i > 4) ? "R9 past end" : "R7 reset byte", v, exp_rst[i]);
      end
      bus_stop();

      // R1 foreign address ignored
      bus_start();
      wb(8'hA4, ack); chk("R1 foreign addr nack", ack, 0);
      wb(8'h01, ack); chk("R1 stays released", ack, 0);
      bus_stop();
      chk("R1 out_en untouched", out_en, 8'hFF);

      // table walk: single-byte write then single-byte read
      for (int i = 0; i < 7; i++) begin
         tag = (VEC[i][23:16] == 8'h00) ? "R8" : (VEC[i][23:16] < 8'h03) ? "R2" : "R9";
         bus_start();
         wb(AW, ack);
         wb(VEC[i][23:16], ack);
         wb(8'h01, ack);
         wb(VEC[i][15:8], ack); chk({tag, " data ack"}, ack, 1);
         bus_stop();
         bus_start();
         wb(AW, ack);
         wb(VEC[i][23:16], ack);
         bus_rstart();
         wb(AR, ack);
         rb(v, 1'b1); chk("R5 count", v, 8'h08);
         rb(v, 1'b0); chk({tag, " readback"}, v, VEC[i][7:0]);
         bus_stop();
      end
      chk("R8 mode after table", {pd_drive, stop_drive, mode_sel}, 0);
      chk("R9 out_en after table", out_en, 8'hA5);
      chk("R9 free_run after table", free_run, 8'h3C);

      // R2 multi-byte block write with auto-increment
      bus_start();
      wb(AW, ack); wb(8'h00, ack); wb(8'h03, ack);
      wb(8'h81, ack); chk("R2 byte0 ack", ack, 1);
      wb(8'h5A, ack); chk("R2 byte1 ack", ack, 1);
      wb(8'hC3, ack); chk("R2 byte2 ack", ack, 1);
      bus_stop();
      chk("R8 pd_drive", pd_drive, 1);
      chk("R8 stop_drive", stop_drive, 0);
      chk("R8 mode_sel", mode_sel, 3'b001);
      chk("R2 out_en", out_en, 8'h5A);
      chk("R2 free_run", free_run, 8'hC3);

      // R5 block read from index 1
      bus_start();
      wb(AW, ack); wb(8'h01, ack);
      bus_rstart();
      wb(AR, ack);
      rb(v, 1'b1); chk("R5 count", v, 8'h08);
      rb(v, 1'b1); chk("R5 idx1", v, 8'h5A);
      rb(v, 1'b1); chk("R5 idx2", v, 8'hC3);
      rb(v, 1'b1); chk("R5 idx3", v, 8'h00);
      rb(v, 1'b0); chk("R5 idx4", v, 8'h05);
      chk("R6 release after nack", sda_pull, 0);
      bus_stop();

      // R3 zero count
      bus_start();
      wb(AW, ack); wb(8'h01, ack);
      wb(8'h00, ack); chk("R3 zero count nack", ack, 0);
      wb(8'h00, ack); chk("R3 data after zero count nack", ack, 0);
      bus_stop();
      chk("R3 out_en kept", out_en, 8'h5A);

      // R4 byte past the count
      bus_start();
      wb(AW, ack); wb(8'h01, ack); wb(8'h01, ack);
      wb(8'h11, ack); chk("R4 counted byte ack", ack, 1);
      wb(8'h22, ack); chk("R4 extra byte nack", ack, 0);
      bus_stop();
      chk("R4 out_en", out_en, 8'h11);
      chk("R4 free_run kept", free_run, 8'hC3);

      // R6 STOP mid-write, then a normal transfer
      bus_start();
      wb(AW, ack); wb(8'h02, ack);
      bus_stop();
      chk("R6 release after stop", sda_pull, 0);
      bus_start();
      wb(AW, ack); wb(8'h02, ack);
      bus_rstart();
      wb(AR, ack); chk("R6 next transfer ack", ack, 1);
      rb(v, 1'b0); chk("R6 count then nack", v, 8'h08);
      chk("R6 release after count nack", sda_pull, 0);
      bus_stop();
      chk("R6 free_run kept", free_run, 8'hC3);

      chk("R10 no change while SCL high", r10_viol, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule